// File: doc/BRIEF.md
# Time-of-Day Counter with Compare Interrupt

This block keeps a free-running 64-bit time value whose bit weights are fixed: bit 12 is worth one microsecond, so the whole word keeps the same meaning at any clock rate. Once every `TICK_DIV` clock cycles the counter adds a constant `INC`. That constant is chosen to match the real clock rate. Bits below position `LSB` never count and always read as zero.

Software reads the time through a small register port. A read of the low half latches the high half into a shadow register, so the two halves together form one consistent 64-bit sample. Any two low-half reads return different values, even when they fall inside the same tick. A read inside the same tick returns the previous result plus one step at the lowest counting bit.

Software arms a delay by writing a compare value, normally the current time plus the delay. The compare value is written as a staged high half followed by a committing low half. The interrupt flag sets whenever the time is at or past the compare value, and it stays set until software clears it. A load port sets a new time.

Top module: `tod_timer`

## Requirements
- R1: After reset the time is zero, the interrupt output is low, a low-half read returns 0 and the status register (address 4) reads 0.
- R2: Starting from reset or from a load, the time increases by exactly `INC` once every `TICK_DIV` clock cycles and does not change in any other cycle.
- R3: Bits of the time below position `LSB` are zero in every value read at address 0. This includes a value loaded with those bits set.
- R4: A low-half read (rd=1, addr=0) returns the current time when that time is larger than the previous low-half result. Otherwise it returns the previous result plus 2^LSB. The first read after reset or after a load returns the current time. Consecutive low-half reads therefore never repeat.
- R5: A read at address 1 returns bits 63:32 of the most recent low-half result, whatever ticks have happened since.
- R6: A write to address 3 only stages the compare high half, and addresses 2 and 3 still read the old compare value. A write to address 2 commits {staged high, written low} as the new compare value. Addresses 2 and 3 read back the committed value. After reset the compare value is all ones.
- R7: The cycle after the time is greater than or equal to the compare value, irq goes high. This also happens when the compare value lies in the past. irq then stays high on its own.
- R8: A write to address 4 with wdata bit 0 = 1 clears irq only when the time is below the compare value. While the time is still at or past the compare value, irq stays high. Address 4 reads irq in bit 0.
- R9: Asserting load for one cycle sets the time to load_val with the bits below `LSB` forced to zero. Counting restarts a full `TICK_DIV` period from that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rd | input | 1 | Read strobe, one cycle per access |
| wr | input | 1 | Write strobe, one cycle per access |
| addr | input | 3 | Register select: 0 time low, 1 time high shadow, 2 compare low, 3 compare high, 4 status/clear |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the same cycle as rd |
| load | input | 1 | Load the time from load_val |
| load_val | input | 64 | New time value |
| irq | output | 1 | Compare interrupt, held until cleared |

## Verification
Four rules are checked by assertions in every cycle:
- the time moves only by `INC` or by a load;
- low-half reads never repeat and their low bits stay zero;
- the shadow changes only on a low-half read, and a staged high write leaves the compare value alone;
- a set flag stays set unless a clear is written.

The bench scenarios cover the timing and arithmetic that no assertion can predict:
- exact tick positions after reset and after a load, and the bumped values when reads fall in the same tick;
- a high-half carry across the 32-bit boundary;
- the exact cycle in which the flag rises for a future compare value;
- a clear that is ignored while the compare condition still holds.

// File: rtl/tod_timer.sv
`timescale 1ns/1ps
module tod_timer #(
  parameter int          LSB      = 4,
  parameter logic [63:0] INC      = 64'h50,
  parameter int          TICK_DIV = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rd,
  input  logic        wr,
  input  logic [2:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  input  logic        load,
  input  logic [63:0] load_val,
  output logic        irq
);
  localparam logic [63:0] UNIT = 64'd1 << LSB;
  localparam logic [63:0] MASK = ~(UNIT - 64'd1);
  localparam int          PW   = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [PW-1:0] pre;
  logic [63:0]   count, last, cmp, rd_val;
  logic          last_ok;
  logic [31:0]   shadow, stage;

  wire tick  = (pre == PW'(TICK_DIV - 1));
  wire lo_rd = rd && (addr == 3'd0);
  wire clr   = wr && (addr == 3'd4) && wdata[0];

  assign rd_val = (!last_ok || count > last) ? count : last + UNIT;

  always_comb begin
    case (addr)
      3'd0:    rdata = rd_val[31:0];
      3'd1:    rdata = shadow;
      3'd2:    rdata = cmp[31:0];
      3'd3:    rdata = cmp[63:32];
      3'd4:    rdata = {31'd0, irq};
      default: rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre     <= '0;
      count   <= '0;
      last    <= '0;
      last_ok <= 1'b0;
      shadow  <= '0;
      stage   <= '0;
      cmp     <= '1;
      irq     <= 1'b0;
    end else begin
      if (load) begin
        count   <= load_val & MASK;
        pre     <= '0;
        last_ok <= 1'b0;
      end else begin
        pre <= tick ? '0 : pre + PW'(1);
        if (tick) count <= count + INC;
        if (lo_rd) begin
          last    <= rd_val;
          last_ok <= 1'b1;
          shadow  <= rd_val[63:32];
        end
      end
      if (wr && addr == 3'd3) stage <= wdata;
      if (wr && addr == 3'd2) cmp   <= {stage, wdata};
      irq <= (count >= cmp) | (irq & ~clr);
    end
  end
endmodule

// File: rtl/tod_timer_chk.sv
`timescale 1ns/1ps
module tod_timer_chk #(
  parameter int          LSB = 4,
  parameter logic [63:0] INC = 64'h50
) (
  input logic        clk,
  input logic        rst_n,
  input logic        rd,
  input logic        wr,
  input logic [2:0]  addr,
  input logic [31:0] wdata,
  input logic [31:0] rdata,
  input logic        load,
  input logic        irq,
  input logic [63:0] count,
  input logic [63:0] cmp,
  input logic [31:0] shadow
);
  logic [31:0] prev_lo;
  logic        seen;
  wire lo_rd = rd && (addr == 3'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_lo <= '0;
      seen    <= 1'b0;
    end else if (load) begin
      seen <= 1'b0;
    end else if (lo_rd) begin
      prev_lo <= rdata;
      seen    <= 1'b1;
    end
  end

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (count == $past(count) || count == $past(count) + INC));

  p_low_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lo_rd |-> rdata[LSB-1:0] == '0);

  p_unique_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_rd && seen && !load) |-> rdata != prev_lo);

  p_shadow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(lo_rd && !load) |=> $stable(shadow));

  p_stage_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && addr == 3'd2) |=> $stable(cmp));

  p_irq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(wr && addr == 3'd4 && wdata[0])) |=> irq);
endmodule

bind tod_timer tod_timer_chk #(.LSB(LSB), .INC(INC)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd(rd), .wr(wr), .addr(addr), .wdata(wdata),
  .rdata(rdata), .load(load), .irq(irq), .count(count), .cmp(cmp),
  .shadow(shadow)
);

// File: tb/tod_timer_test.sv
`timescale 1ns/1ps
module tod_timer_test;
  localparam int          LSB = 4;
  localparam logic [63:0] INC = 64'h50;
  localparam int          DIV = 3;
  localparam logic [63:0] UNIT = 64'd1 << LSB;
  localparam logic [63:0] MASK = ~(UNIT - 64'd1);

  logic clk = 0, rst_n = 0, rd = 0, wr = 0, load = 0;
  logic [2:0]  addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic [63:0] load_val = 0;
  logic        irq;

  tod_timer #(.LSB(LSB), .INC(INC), .TICK_DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .rd(rd), .wr(wr), .addr(addr), .wdata(wdata),
    .rdata(rdata), .load(load), .load_val(load_val), .irq(irq));

  always #2.5 clk = ~clk;

  int ecount = 0;
  always @(posedge clk) if (rst_n) ecount <= ecount + 1;

  int checks = 0, errors = 0;
  bit done = 0;
  int lorg = 0;
  logic [63:0] lbase = 0, last_m = 0, cmpv;
  bit ok_m = 0;
  logic [31:0] shadow_m = 0, v;

  function automatic logic [63:0] cnt_at(int e);
    return lbase + INC * 64'((e - lorg) / DIV);
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    rd = 1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    rd = 0;
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    wr = 1; addr = a; wdata = d;
    @(negedge clk);
    wr = 0;
  endtask

  task automatic do_load(input logic [63:0] val);
    load = 1; load_val = val;
    lorg = ecount + 1; lbase = val & MASK; ok_m = 0;
    @(negedge clk);
    load = 0;
  endtask

  task automatic lo_check(string tag);
    logic [63:0] c, exp;
    c = cnt_at(ecount);
    exp = (!ok_m || c > last_m) ? c : last_m + UNIT;
    rd_reg(3'd0, v);
    chk(tag, {32'd0, v}, {32'd0, exp[31:0]});
    last_m = exp; ok_m = 1; shadow_m = exp[63:32];
  endtask

  task automatic sweep(string tag);
    for (int k = 1; k <= 4; k++)
      for (int n = 0; n < 12; n++) begin
        lo_check(tag);
        if (n % 3 == 0) begin
          rd_reg(3'd1, v);
          chk("R5 shadow high", {32'd0, v}, {32'd0, shadow_m});
        end
        repeat (k - 1) @(negedge clk);
      end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1 irq after reset", {63'd0, irq}, 64'd0);
    lo_check("R1 time zero");
    rd_reg(3'd4, v);
    chk("R1 status zero", {32'd0, v}, 64'd0);
    rd_reg(3'd2, v);
    chk("R6 cmp reset low", {32'd0, v}, 64'hFFFF_FFFF);

    sweep("R2 R4 sweep from reset");

    do_load(64'h0000_0001_FFFF_FF0F);
    lo_check("R9 R3 load masks low bits");
    sweep("R2 R4 sweep across 32-bit carry");
    repeat (400) @(negedge clk);
    rd_reg(3'd1, v);
    chk("R5 shadow stable after ticks", {32'd0, v}, {32'd0, shadow_m});
    lo_check("R4 read after long gap");

    rd_reg(3'd3, v);
    chk("R6 cmp hi before", {32'd0, v}, 64'hFFFF_FFFF);
    wr_reg(3'd3, 32'h0000_0000);
    rd_reg(3'd3, v);
    chk("R6 staged hi not visible", {32'd0, v}, 64'hFFFF_FFFF);
    wr_reg(3'd2, 32'h0000_1000);
    rd_reg(3'd3, v);
    chk("R6 commit hi", {32'd0, v}, 64'd0);
    rd_reg(3'd2, v);
    chk("R6 commit lo", {32'd0, v}, 64'h1000);
    cmpv = 64'h1000;

    repeat (2) @(negedge clk);
    chk("R7 past compare fires", {63'd0, irq}, 64'd1);
    repeat (20) @(negedge clk);
    chk("R7 level held", {63'd0, irq}, 64'd1);
    wr_reg(3'd4, 32'd1);
    @(negedge clk);
    chk("R8 clear ignored while past", {63'd0, irq}, 64'd1);
    rd_reg(3'd4, v);
    chk("R8 status shows irq", {32'd0, v}, 64'd1);

    cmpv = cnt_at(ecount) + INC * 10;
    wr_reg(3'd3, cmpv[63:32]);
    wr_reg(3'd2, cmpv[31:0]);
    wr_reg(3'd4, 32'd1);
    @(negedge clk);
    chk("R8 clear with future compare", {63'd0, irq}, 64'd0);
    while (cnt_at(ecount) < cmpv) begin
      if (irq !== 1'b0) chk("R7 no early irq", {63'd0, irq}, 64'd0);
      @(negedge clk);
    end
    chk("R7 irq one cycle after match", {63'd0, irq}, 64'd0);
    @(negedge clk);
    chk("R7 irq rises", {63'd0, irq}, 64'd1);

    do_load(64'd0);
    lo_check("R9 reload zero");
    sweep("R2 R4 sweep after reload");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule